// File: doc/BRIEF.md
# Command Frame Descriptor Generator

This block sits behind an Ethernet receive path and turns IP-encapsulated commands into entries for a command queue. It watches a stream of 32-bit words that carry start-of-frame, end-of-frame and valid qualifiers. It reads the IPv4 total length and destination address and throws away any frame that is not addressed to the programmed local address. For an accepted frame it then decodes a command word that carries a target code, a command kind and a sequence number.

Before it stores any payload, the block asks the buffer memory controller for space sized in payload words. If the controller grants the request, the payload words are written to consecutive buffer locations starting at the granted base address. At the end of the frame a descriptor is offered to the command FIFO. The descriptor holds the target, kind, sequence number, buffer start and word count. A refused request, a foreign address or a truncated header all make the block silently discard the frame. A full FIFO at descriptor time also discards it, and this case is counted.

Top module: `cmd_desc_gen`

## Requirements
- R1: While reset is held and after it is released with no input, `wr_req`, `buf_we` and `fifo_push` are low and `drop_count` is zero.
- R2: A frame begins with the word carrying `in_sof`. Word 0 bits [15:0] hold the IP total length in bytes, word 4 holds the destination address, and word 5 is the command word: bits [31:27] target code, [26:24] command kind, [15:0] sequence number. Payload words follow from word 6.
- R3: A frame whose word 4 differs from `local_ip` causes no request, no buffer write and no descriptor.
- R4: `wr_req` is high combinationally in the cycle that word 5 is presented, and only then. In that cycle `wr_size` equals ceil((total length - 24) / 4), or 0 when the total length is below 24.
- R5: The request is granted only when `mem_ack` is high and `mem_nack` is low in the same cycle. Otherwise the frame produces no buffer write and no descriptor.
- R6: After a grant, the k-th payload word (k from 0) is written in the cycle after it arrives, with `buf_addr` = (`mem_base` + k) mod 2^ADDR_W and `buf_wdata` equal to the word. Words beyond `wr_size` are not written.
- R7: The descriptor of a granted frame is offered in the cycle after its end-of-frame word as {target[4:0], kind[2:0], seq[15:0], base[ADDR_W-1:0], words[15:0]} from MSB to LSB, and `fifo_push` is high for exactly that one cycle.
- R8: If `fifo_full` is high in the descriptor cycle, `fifo_push` stays low and `drop_count` rises by one, saturating at 2^DROP_W - 1.
- R9: A frame that ends before word 5, or that is cut by a new `in_sof`, has no side effects. A new `in_sof` restarts parsing.
- R10: Cycles with `in_valid` low are ignored inside a frame, and valid words that arrive outside a frame without `in_sof` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| local_ip | input | 32 | Programmed local IPv4 address |
| in_valid | input | 1 | Input word valid |
| in_sof | input | 1 | First word of a frame |
| in_eof | input | 1 | Last word of a frame |
| in_data | input | 32 | Input word |
| wr_req | output | 1 | Buffer space request |
| wr_size | output | 16 | Requested size in words |
| mem_ack | input | 1 | Request granted (same cycle) |
| mem_nack | input | 1 | Request refused (same cycle) |
| mem_base | input | ADDR_W | Granted buffer start address |
| buf_we | output | 1 | Buffer write strobe |
| buf_addr | output | ADDR_W | Buffer write address |
| buf_wdata | output | 32 | Buffer write data |
| fifo_full | input | 1 | Command FIFO full |
| fifo_push | output | 1 | Descriptor push |
| fifo_desc | output | 40+ADDR_W | Descriptor |
| drop_count | output | DROP_W | Saturating count of descriptors lost to a full FIFO |

## Verification
The bench targets total lengths that are not a multiple of four and frames that carry more words than their length announces. A design that got the rounding wrong would request one word too few or too many, and a design that ignored the size would write the extra words. It sends payloads that cross the top of the address space from a base near the end, where a design without modular addressing would write out of range. It also sends frames cut inside the header, frames restarted by a second start-of-frame, refused grants, foreign addresses and a header-only frame of size zero. On these, a faulty design would leak writes or descriptors. Enough descriptors arrive with the FIFO full to reach the counter ceiling, which catches a counter that wraps to zero.

// File: rtl/cdg_pkg.sv
package cdg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_PAY  = 2'd2,
        ST_DROP = 2'd3
    } cdg_state_e;

    // fixed word positions inside a frame
    localparam int unsigned WORD_DST = 4;
    localparam int unsigned WORD_CMD = 5;
    // bytes ahead of the payload: 20 of IP header plus the command word
    localparam int unsigned HDR_BYTES = 24;

    localparam int unsigned TGT_W = 5;
    localparam int unsigned KIND_W = 3;
    localparam int unsigned SEQ_W = 16;
    localparam int unsigned LEN_W = 16;
endpackage

// File: rtl/cdg_len_calc.sv
module cdg_len_calc
    import cdg_pkg::*;
(
    input  logic [LEN_W-1:0] tot_len,
    output logic [LEN_W-1:0] words
);
    localparam logic [LEN_W-1:0] HDR_LEN = LEN_W'(HDR_BYTES);

    logic [LEN_W-1:0] pay_bytes;
    logic [LEN_W-1:0] rounded;

    always_comb begin
        pay_bytes = tot_len - HDR_LEN;
        rounded   = pay_bytes + LEN_W'(3);
        if (tot_len < HDR_LEN) begin
            words = '0;
        end else begin
            words = {2'b00, rounded[LEN_W-1:2]};
        end
    end
endmodule

// File: rtl/cdg_sat_counter.sv
module cdg_sat_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && (cnt_q != TOP)) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/cmd_desc_gen.sv
module cmd_desc_gen
    import cdg_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DROP_W = 8,
    localparam int unsigned DESC_W = TGT_W + KIND_W + SEQ_W + ADDR_W + LEN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       local_ip,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [31:0]       in_data,
    output logic              wr_req,
    output logic [LEN_W-1:0]  wr_size,
    input  logic              mem_ack,
    input  logic              mem_nack,
    input  logic [ADDR_W-1:0] mem_base,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [31:0]       buf_wdata,
    input  logic              fifo_full,
    output logic              fifo_push,
    output logic [DESC_W-1:0] fifo_desc,
    output logic [DROP_W-1:0] drop_count
);
    localparam int unsigned IDX_W = 3;
    localparam logic [IDX_W-1:0] IDX_DST = IDX_W'(WORD_DST);
    localparam logic [IDX_W-1:0] IDX_CMD = IDX_W'(WORD_CMD);

    typedef struct packed {
        cdg_state_e         st;
        logic [IDX_W-1:0]   idx;
        logic [LEN_W-1:0]   tlen;
        logic [TGT_W-1:0]   tgt;
        logic [KIND_W-1:0]  kind;
        logic [SEQ_W-1:0]   seq;
        logic [ADDR_W-1:0]  base;
        logic [LEN_W-1:0]   size;
        logic [LEN_W-1:0]   cnt;
        logic               pend;
        logic               we;
        logic [ADDR_W-1:0]  waddr;
        logic [31:0]        wdata;
    } cdg_state_t;

    cdg_state_t s_d, s_q;
    logic [LEN_W-1:0] req_words;
    logic             grant;
    logic             drop_inc;

    cdg_len_calc u_len (
        .tot_len (s_q.tlen),
        .words   (req_words)
    );

    assign grant = mem_ack && !mem_nack;

    always_comb begin
        s_d      = s_q;
        s_d.we   = 1'b0;
        s_d.pend = 1'b0;
        wr_req   = 1'b0;
        if (in_valid) begin
            if (in_sof) begin
                s_d.st   = ST_HDR;
                s_d.idx  = IDX_W'(1);
                s_d.tlen = in_data[LEN_W-1:0];
            end else begin
                unique case (s_q.st)
                    ST_HDR: begin
                        s_d.idx = s_q.idx + IDX_W'(1);
                        if ((s_q.idx == IDX_DST) && (in_data != local_ip)) begin
                            s_d.st = ST_DROP;
                        end
                        if (s_q.idx == IDX_CMD) begin
                            wr_req   = 1'b1;
                            s_d.tgt  = in_data[31:27];
                            s_d.kind = in_data[26:24];
                            s_d.seq  = in_data[SEQ_W-1:0];
                            s_d.size = req_words;
                            s_d.cnt  = '0;
                            if (grant) begin
                                s_d.base = mem_base;
                                s_d.st   = ST_PAY;
                            end else begin
                                s_d.st   = ST_DROP;
                            end
                        end
                    end
                    ST_PAY: begin
                        if (s_q.cnt < s_q.size) begin
                            s_d.we    = 1'b1;
                            s_d.waddr = s_q.base + ADDR_W'(s_q.cnt);
                            s_d.wdata = in_data;
                            s_d.cnt   = s_q.cnt + LEN_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
            if (in_eof) begin
                s_d.pend = (s_d.st == ST_PAY);
                s_d.st   = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign drop_inc = s_q.pend && fifo_full;

    cdg_sat_counter #(.W(DROP_W)) u_drop (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (drop_inc),
        .count (drop_count)
    );

    assign wr_size   = req_words;
    assign buf_we    = s_q.we;
    assign buf_addr  = s_q.waddr;
    assign buf_wdata = s_q.wdata;
    assign fifo_push = s_q.pend && !fifo_full;
    assign fifo_desc = {s_q.tgt, s_q.kind, s_q.seq, s_q.base, s_q.size};
endmodule

// File: rtl/cmd_desc_gen_chk.sv
module cmd_desc_gen_chk #(
    parameter int unsigned DROP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_sof,
    input logic              wr_req,
    input logic              fifo_full,
    input logic              fifo_push,
    input logic [DROP_W-1:0] drop_count
);
    // R4: a request only rides on a presented, non-start word
    p_req_on_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (in_valid && !in_sof));

    // R8: never push into a full queue
    p_push_room_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> !fifo_full);

    // R7: a push lasts one cycle
    p_push_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |=> !fifo_push);

    // R8: the loss counter only ever steps up by one
    p_drop_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count != $past(drop_count)) |-> (drop_count == $past(drop_count) + DROP_W'(1)));
endmodule

bind cmd_desc_gen cmd_desc_gen_chk #(.DROP_W(DROP_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sof     (in_sof),
    .wr_req     (wr_req),
    .fifo_full  (fifo_full),
    .fifo_push  (fifo_push),
    .drop_count (drop_count)
);

// File: tb/cmd_desc_gen_tb_top.sv
module cmd_desc_gen_tb_top;
    localparam int ADDR_W = 10;
    localparam int DROP_W = 8;
    localparam int DESC_W = 40 + ADDR_W;
    localparam int AMOD   = 1 << ADDR_W;
    localparam int DMAX   = (1 << DROP_W) - 1;
    localparam logic [31:0] MY_IP = 32'h0A00_0105;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic              in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [31:0]       in_data = '0;
    logic              wr_req;
    logic [15:0]       wr_size;
    logic              mem_ack, mem_nack;
    logic [ADDR_W-1:0] mem_base;
    logic              buf_we;
    logic [ADDR_W-1:0] buf_addr;
    logic [31:0]       buf_wdata;
    logic              fifo_full = 1'b0;
    logic              fifo_push;
    logic [DESC_W-1:0] fifo_desc;
    logic [DROP_W-1:0] drop_count;
    logic              grant_en = 1'b1;
    logic [ADDR_W-1:0] base_val = 10'h040;

    assign mem_ack  = wr_req && grant_en;
    assign mem_nack = wr_req && !grant_en;
    assign mem_base = base_val;

    cmd_desc_gen #(.ADDR_W(ADDR_W), .DROP_W(DROP_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .local_ip(MY_IP),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .wr_req(wr_req), .wr_size(wr_size), .mem_ack(mem_ack), .mem_nack(mem_nack),
        .mem_base(mem_base), .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .fifo_full(fifo_full), .fifo_push(fifo_push), .fifo_desc(fifo_desc),
        .drop_count(drop_count)
    );

    int n_chk = 0, n_fail = 0;
    int n_req = 0, n_we = 0, n_push = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: 0 idle, 1 header, 2 payload, 3 discard
    int m_mode = 0, m_idx = 0, m_tlen = 0, m_size = 0, m_k = 0, m_base = 0;
    int m_tgt = 0, m_kind = 0, m_seq = 0;
    int exp_drop = 0, exp_addr = 0;
    bit exp_we = 0, exp_pend = 0;
    logic [31:0] exp_data = '0;

    function automatic int words_of(input int t);
        return (t < 24) ? 0 : (t - 24 + 3) / 4;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_idx = 0; exp_drop = 0; exp_we = 0; exp_pend = 0;
        end else begin
            if (exp_pend && fifo_full && exp_drop < DMAX) exp_drop++;
            exp_pend = 0;
            exp_we = 0;
            if (in_valid) begin
                if (in_sof) begin
                    m_mode = 1; m_idx = 1; m_tlen = int'(in_data[15:0]);
                end else if (m_mode == 1) begin
                    if (m_idx == 4 && in_data != MY_IP) m_mode = 3;
                    else if (m_idx == 5) begin
                        m_tgt = int'(in_data[31:27]); m_kind = int'(in_data[26:24]);
                        m_seq = int'(in_data[15:0]); m_size = words_of(m_tlen);
                        if (grant_en) begin
                            m_base = int'(base_val); m_k = 0; m_mode = 2;
                        end else m_mode = 3;
                    end
                    m_idx++;
                end else if (m_mode == 2) begin
                    if (m_k < m_size) begin
                        exp_we = 1; exp_addr = (m_base + m_k) % AMOD; exp_data = in_data; m_k++;
                    end
                end
                if (in_eof) begin
                    if (m_mode == 2) exp_pend = 1;
                    m_mode = 0;
                end
            end
        end
    end

    // compare every cycle, away from the edge
    always @(negedge clk) begin
        #1;
        if (rst_n && !finished) begin
            bit er;
            logic [DESC_W-1:0] ed;
            er = in_valid && !in_sof && m_mode == 1 && m_idx == 5;
            chk(wr_req == er, "R4 wr_req", longint'(wr_req), longint'(er));
            if (er) chk(int'(wr_size) == words_of(m_tlen), "R4 wr_size", longint'(wr_size), longint'(words_of(m_tlen)));
            chk(buf_we == exp_we, "R6 buf_we", longint'(buf_we), longint'(exp_we));
            if (exp_we && buf_we) begin
                chk(int'(buf_addr) == exp_addr, "R6 buf_addr", longint'(buf_addr), longint'(exp_addr));
                chk(buf_wdata == exp_data, "R6 buf_wdata", longint'(buf_wdata), longint'(exp_data));
            end
            chk(fifo_push == (exp_pend && !fifo_full), "R7 fifo_push", longint'(fifo_push), longint'(exp_pend && !fifo_full));
            if (fifo_push) begin
                ed = {5'(m_tgt), 3'(m_kind), 16'(m_seq), ADDR_W'(m_base), 16'(m_size)};
                chk(fifo_desc == ed, "R7 fifo_desc", longint'(fifo_desc), longint'(ed));
            end
            chk(int'(drop_count) == exp_drop, "R8 drop_count", longint'(drop_count), longint'(exp_drop));
            if (wr_req) n_req++;
            if (buf_we) n_we++;
            if (fifo_push) n_push++;
        end
    end

    task automatic put(input bit s, input bit e, input logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_sof = s; in_eof = e; in_data = d;
    endtask

    task automatic gap();
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 32'hBAD0_BAD0;
    endtask

    task automatic send(input logic [31:0] dst, input int tlen, input int tgt, input int kind,
                        input int seq, input int npay, input int cut, input bit gaps);
        int total;
        total = (cut >= 0) ? cut + 1 : 6 + npay;
        for (int i = 0; i < total; i++) begin
            logic [31:0] w;
            case (i)
                0: w = {16'h4500, 16'(tlen)};
                1: w = 32'h1234_4000;
                2: w = 32'h4011_0000;
                3: w = 32'hC0A8_0001;
                4: w = dst;
                5: w = {5'(tgt), 3'(kind), 8'h00, 16'(seq)};
                default: w = 32'hD000_0000 + 32'(i) + 32'(seq << 8);
            endcase
            put(i == 0, i == total - 1, w);
            if (gaps && (i % 2 == 0)) gap();
        end
        gap(); gap(); gap();
    endtask

    task automatic expect_counts(input string tag, input int r0, input int w0, input int p0,
                                 input int er, input int ew, input int ep);
        chk(n_req - r0 == er, {tag, " requests"}, longint'(n_req - r0), longint'(er));
        chk(n_we - w0 == ew, {tag, " writes"}, longint'(n_we - w0), longint'(ew));
        chk(n_push - p0 == ep, {tag, " pushes"}, longint'(n_push - p0), longint'(ep));
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int r0, w0, p0;
        repeat (3) @(negedge clk);
        #1;
        chk(!wr_req && !buf_we && !fifo_push && drop_count == 0, "R1 in reset",
            longint'({wr_req, buf_we, fifo_push}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(!wr_req && !buf_we && !fifo_push && drop_count == 0, "R1 after reset",
            longint'({wr_req, buf_we, fifo_push}), 0);

        // R2 R7: plain frame, 16 payload bytes
        r0 = n_req; w0 = n_we; p0 = n_push;
        send(MY_IP, 40, 2, 2, 16'h0101, 4, -1, 1'b0);
        expect_counts("R2 R7 plain", r0, w0, p0, 1, 4, 1);

        // R6 R10: odd length rounds up, extra words skipped, idle gaps
        r0 = n_req; w0 = n_we; p0 = n_push;
        send(MY_IP, 34, 1, 1, 16'h0202, 5, -1, 1'b1);
        expect_counts("R6 R10 rounding", r0, w0, p0, 1, 3, 1);

        // R3: foreign destination
        r0 = n_req; w0 = n_we; p0 = n_push;
        send(32'h0A00_0106, 40, 0, 0, 16'h0303, 4, -1, 1'b0);
        expect_counts("R3 foreign", r0, w0, p0, 0, 0, 0);

        // R5: refused grant
        grant_en = 1'b0;
        r0 = n_req; w0 = n_we; p0 = n_push;
        send(MY_IP, 40, 3, 2, 16'h0404, 4, -1, 1'b0);
        expect_counts("R5 refused", r0, w0, p0, 1, 0, 0);
        grant_en = 1'b1;

        // R9: frame cut inside the header
        r0 = n_req; w0 = n_we; p0 = n_push;
        send(MY_IP, 40, 3, 2, 16'h0505, 4, 3, 1'b0);
        expect_counts("R9 short", r0, w0, p0, 0, 0, 0);

        // R9: restart by a new start word
        r0 = n_req; w0 = n_we; p0 = n_push;
        put(1'b1, 1'b0, 32'h4500_0028);
        put(1'b0, 1'b0, 32'h1234_4000);
        put(1'b0, 1'b0, 32'h4011_0000);
        send(MY_IP, 28, 4, 0, 16'h0606, 1, -1, 1'b0);
        expect_counts("R9 restart", r0, w0, p0, 1, 1, 1);

        // R10: stray words outside a frame
        r0 = n_req; w0 = n_we; p0 = n_push;
        put(1'b0, 1'b0, MY_IP);
        put(1'b0, 1'b0, 32'h1000_0001);
        put(1'b0, 1'b1, 32'h1000_0002);
        gap(); gap();
        expect_counts("R10 stray", r0, w0, p0, 0, 0, 0);

        // R6: address wrap at the top of the buffer
        base_val = 10'h3FC;
        r0 = n_req; w0 = n_we; p0 = n_push;
        send(MY_IP, 48, 2, 2, 16'h0707, 6, -1, 1'b0);
        expect_counts("R6 wrap", r0, w0, p0, 1, 6, 1);
        base_val = 10'h100;

        // R4: header-only frame of size zero
        r0 = n_req; w0 = n_we; p0 = n_push;
        send(MY_IP, 20, 0, 0, 16'h0808, 0, -1, 1'b0);
        expect_counts("R4 empty", r0, w0, p0, 1, 0, 1);

        // R8: full queue, count to the ceiling
        fifo_full = 1'b1;
        r0 = n_req; w0 = n_we; p0 = n_push;
        for (int f = 0; f < DMAX + 4; f++) begin
            send(MY_IP, 24, 1, 0, f, 0, -1, 1'b0);
        end
        expect_counts("R8 full", r0, w0, p0, DMAX + 4, 0, 0);
        #1;
        chk(int'(drop_count) == DMAX, "R8 saturation", longint'(drop_count), longint'(DMAX));
        fifo_full = 1'b0;

        // R7: queue free again
        r0 = n_req; w0 = n_we; p0 = n_push;
        send(MY_IP, 32, 3, 1, 16'h0909, 2, -1, 1'b0);
        expect_counts("R7 after full", r0, w0, p0, 1, 2, 1);

        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule